// File: doc/BRIEF.md
# Frame Signature MISR Collector

This block condenses the pixel stream leaving a display interface into a 32-bit signature, so that software can compare rendered frames against known-good values without capturing the pixels themselves. Each valid pixel word is folded into a shift-register accumulator. The accumulation window is bounded by frame-start pulses and spans a programmed number of frames.

Software drives the block through a small register port. The usual sequence is: issue a clear command, write a control word that enables collection, poll the done flag, then read the signature register. In free-running mode the block closes one window and opens the next at the same frame boundary. Each finished signature is latched into the readable register without software help, and the done flag stays set.

Top module: `frame_sig_misr`

## Requirements
- R1: After reset the control readback (address 0) and the signature readback (address 1) are both zero, and the done flag is clear.
- R2: Each valid pixel accepted inside a window updates the accumulator to (acc << 1) XOR (POLY if acc bit 31 was set, else 0) XOR the pixel word zero-extended to 32 bits. POLY is 32'h04C11DB7 and the seed is zero. Cycles with pix_valid low leave the accumulator unchanged.
- R3: A window opens at the first frame_start after an enabling control write. A pixel valid in that same cycle is the window's first word, and pixels before the opening pulse are ignored. With a frame count N, the window closes at the (N+1)th frame_start counted from the opening one.
- R4: When a window closes, the accumulated value appears in the signature register and the done flag (control bit 31) is set. The flag stays set until a clear command.
- R5: In single-shot mode (control bit 17 clear), a pixel in the closing cycle is not folded. Later pixels and frame pulses leave the signature unchanged.
- R6: In free-run mode (control bit 17 set), each closing pulse latches the signature and reseeds the accumulator. A pixel valid in the closing cycle becomes the first word of the next window. No software write is needed between windows.
- R7: A control write with bit 30 set clears the accumulator, the signature, the done flag and all control fields. It takes priority over any frame event in the same cycle.
- R8: A control write of zero stops collection. Subsequent frame pulses and pixels neither set the done flag nor change the signature.
- R9: A frame-count field of zero is treated as a window of one frame.
- R10: When the source-select bit (control bit 18) is clear, no pixel is folded, and a completed window yields the seed value (zero).
- R11: The control readback shows the count in bits 15:0, enable in bit 16, free-run in bit 17, source select in bit 18 and done in bit 31. Bit 30 reads as zero. Writes to address 1 are ignored. Read data is registered and reflects rd_addr and the register state one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 signature (read-only) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 1 | Read address: 0 control, 1 signature |
| rd_data | output | 32 | Registered read data |
| pix_valid | input | 1 | Pixel word valid strobe |
| pix_data | input | PIX_W | Pixel word |
| frame_start | input | 1 | One-cycle frame-start pulse |

## Verification
A frame_start pulse and a valid pixel can coincide, and the outcome depends on where that pulse sits in the window. At the opening pulse the pixel must be folded. At a single-shot closing pulse it must be dropped. At a free-running closing pulse it must seed the next window. The bench drives a pixel alongside frame pulses in each of these positions and predicts the signature arithmetically from exactly the pixels that the window rules admit. Any misattributed word changes the 32-bit result. The frame count is swept from zero to five in single-shot mode, and two successive free-running windows are compared separately.

// File: rtl/frame_sig_misr_pkg.sv
package frame_sig_misr_pkg;
  localparam int REG_W    = 32;
  localparam int EN_POS   = 16;
  localparam int FREE_POS = 17;
  localparam int SRC_POS  = 18;
  localparam int CLR_POS  = 30;
  localparam int DONE_POS = 31;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SIG  = 1'b1;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_ARMED = 2'd1,
    WIN_RUN   = 2'd2,
    WIN_HOLD  = 2'd3
  } win_state_e;

  function automatic logic [REG_W-1:0] sig_step(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] poly,
    input logic [REG_W-1:0] din
  );
    sig_step = {cur[REG_W-2:0], 1'b0} ^ (cur[REG_W-1] ? poly : '0) ^ din;
  endfunction
endpackage

// File: rtl/frame_sig_regs.sv
module frame_sig_regs
  import frame_sig_misr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  input  logic             capture,
  input  logic [REG_W-1:0] sig_value,
  output logic [CNT_W-1:0] cfg_count,
  output logic             cfg_en,
  output logic             cfg_free,
  output logic             cfg_sel,
  output logic             clr_cmd,
  output logic             cfg_load,
  output logic             load_en,
  output logic             done,
  output logic [REG_W-1:0] rd_data
);
  logic             ctrl_hit;
  logic [REG_W-1:0] ctrl_word;

  assign ctrl_hit = wr_en && (wr_addr == ADDR_CTRL);
  assign clr_cmd  = ctrl_hit && wr_data[CLR_POS];
  assign cfg_load = ctrl_hit && !wr_data[CLR_POS];
  assign load_en  = wr_data[EN_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_count <= '0;
      cfg_en    <= 1'b0;
      cfg_free  <= 1'b0;
      cfg_sel   <= 1'b0;
      done      <= 1'b0;
    end else if (clr_cmd) begin
      cfg_count <= '0;
      cfg_en    <= 1'b0;
      cfg_free  <= 1'b0;
      cfg_sel   <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (cfg_load) begin
        cfg_count <= wr_data[CNT_W-1:0];
        cfg_en    <= wr_data[EN_POS];
        cfg_free  <= wr_data[FREE_POS];
        cfg_sel   <= wr_data[SRC_POS];
      end
      if (capture) done <= 1'b1;
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CNT_W-1:0]   = cfg_count;
    ctrl_word[EN_POS]      = cfg_en;
    ctrl_word[FREE_POS]    = cfg_free;
    ctrl_word[SRC_POS]     = cfg_sel;
    ctrl_word[DONE_POS]    = done;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_addr == ADDR_SIG) ? sig_value : ctrl_word;
  end

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !clr_cmd) |=> done);
  assert_clear_done_R7: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (!done && !cfg_en));
endmodule

// File: rtl/frame_sig_window.sv
module frame_sig_window
  import frame_sig_misr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_cmd,
  input  logic             cfg_load,
  input  logic             load_en,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_free,
  input  logic             frame_start,
  output logic             open_win,
  output logic             accept,
  output logic             capture,
  output logic             win_hold
);
  localparam int CMP_W = CNT_W + 1;

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] seen_q;
  logic [CMP_W-1:0] target;
  logic             last_frame;

  assign target     = (cfg_count == '0) ? CMP_W'(1) : {1'b0, cfg_count};
  assign last_frame = ({1'b0, seen_q} + CMP_W'(1)) == target;
  assign win_hold   = (state_q == WIN_HOLD);

  always_comb begin
    state_d  = state_q;
    open_win = 1'b0;
    accept   = 1'b0;
    capture  = 1'b0;
    if (!clr_cmd && !cfg_load) begin
      case (state_q)
        WIN_ARMED: begin
          if (frame_start) begin
            open_win = 1'b1;
            accept   = 1'b1;
            state_d  = WIN_RUN;
          end
        end
        WIN_RUN: begin
          if (frame_start && last_frame) begin
            capture = 1'b1;
            if (cfg_free) begin
              open_win = 1'b1;
              accept   = 1'b1;
            end else begin
              state_d = WIN_HOLD;
            end
          end else begin
            accept = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_cmd) begin
      state_q <= WIN_IDLE;
      seen_q  <= '0;
    end else if (cfg_load) begin
      state_q <= load_en ? WIN_ARMED : WIN_IDLE;
      seen_q  <= '0;
    end else begin
      state_q <= state_d;
      if (open_win)                            seen_q <= '0;
      else if (state_q == WIN_RUN && frame_start) seen_q <= seen_q + 1'b1;
    end
  end

  assert_close_on_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    capture |-> frame_start);
  assert_unit_window_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == WIN_RUN && frame_start && cfg_count == '0 && !clr_cmd && !cfg_load)
      |-> capture);
  assert_single_parks_R5: assert property (@(posedge clk) disable iff (rst)
    (capture && !cfg_free) |=> win_hold);
endmodule

// File: rtl/frame_sig_lfsr.sv
module frame_sig_lfsr
  import frame_sig_misr_pkg::*;
#(
  parameter int             PIX_W = 24,
  parameter logic [REG_W-1:0] POLY = 32'h04C1_1DB7,
  parameter logic [REG_W-1:0] SEED = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             reseed,
  input  logic             open_win,
  input  logic             accept,
  input  logic             capture,
  input  logic             pix_valid,
  input  logic             pix_sel,
  input  logic [PIX_W-1:0] pix_data,
  output logic [REG_W-1:0] acc,
  output logic [REG_W-1:0] sig
);
  logic [REG_W-1:0] base, din_ext, acc_d;
  logic             take;

  assign din_ext = REG_W'(pix_data);
  assign base    = open_win ? SEED : acc;
  assign take    = accept && pix_valid && pix_sel;
  assign acc_d   = take ? sig_step(base, POLY, din_ext) : base;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= SEED;
      sig <= '0;
    end else begin
      acc <= reseed ? SEED : acc_d;
      if (capture) sig <= acc;
    end
  end

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sig == '0 && acc == SEED));
  assert_src_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!pix_sel && !open_win && !reseed && !clear) |=> $stable(acc));
  assert_idle_pixel_R2: assert property (@(posedge clk) disable iff (rst)
    (!pix_valid && !open_win && !reseed && !clear) |=> $stable(acc));
endmodule

// File: rtl/frame_sig_misr.sv
module frame_sig_misr
  import frame_sig_misr_pkg::*;
#(
  parameter int             PIX_W = 24,
  parameter int             CNT_W = 16,
  parameter logic [31:0]    POLY  = 32'h04C1_1DB7,
  parameter logic [31:0]    SEED  = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_addr,
  output logic [31:0]      rd_data,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             frame_start
);
  logic [CNT_W-1:0] cfg_count;
  logic             cfg_en, cfg_free, cfg_sel;
  logic             clr_cmd, cfg_load, load_en, done;
  logic             open_win, accept, capture, win_hold;
  logic [REG_W-1:0] acc, sig;

  frame_sig_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .capture(capture), .sig_value(sig),
    .cfg_count(cfg_count), .cfg_en(cfg_en), .cfg_free(cfg_free), .cfg_sel(cfg_sel),
    .clr_cmd(clr_cmd), .cfg_load(cfg_load), .load_en(load_en), .done(done),
    .rd_data(rd_data)
  );

  frame_sig_window #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .clr_cmd(clr_cmd), .cfg_load(cfg_load), .load_en(load_en),
    .cfg_count(cfg_count), .cfg_free(cfg_free), .frame_start(frame_start),
    .open_win(open_win), .accept(accept), .capture(capture), .win_hold(win_hold)
  );

  frame_sig_lfsr #(.PIX_W(PIX_W), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .clear(clr_cmd), .reseed(cfg_load && load_en),
    .open_win(open_win), .accept(accept), .capture(capture),
    .pix_valid(pix_valid), .pix_sel(cfg_sel), .pix_data(pix_data),
    .acc(acc), .sig(sig)
  );

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (win_hold && !clr_cmd && !cfg_load) |=> $stable(sig));
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |-> !capture);
  assert_capture_sets_done_R4: assert property (@(posedge clk) disable iff (rst)
    capture |=> (done && sig == $past(acc)));
endmodule

// File: tb/frame_sig_misr_tb.sv
`timescale 1ns/1ps
module frame_sig_misr_tb;
  localparam int          PIX_W = 24;
  localparam logic [31:0] POLY  = 32'h04C1_1DB7;
  localparam logic [31:0] BIT_EN = 32'h0001_0000, BIT_FREE = 32'h0002_0000,
                          BIT_SRC = 32'h0004_0000, BIT_CLR = 32'h4000_0000,
                          BIT_DONE = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic pix_valid = 1'b0, frame_start = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;

  int checks = 0, fails = 0;
  logic [31:0] exp_acc, exp_sig;

  always #2.5 clk = ~clk;

  frame_sig_misr u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pix_valid(pix_valid),
    .pix_data(pix_data), .frame_start(frame_start)
  );

  function automatic logic [31:0] step(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r;
    r = a << 1;
    if (a[31]) r = r ^ POLY;
    return r ^ d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic fs, input logic v, input logic [PIX_W-1:0] d);
    frame_start = fs; pix_valid = v; pix_data = d;
    @(negedge clk);
    frame_start = 1'b0; pix_valid = 1'b0; pix_data = '0;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // close: window boundary in the model; fs_pix/fs_cnt: pixel on pulse and whether it folds
  task automatic send_frame(input bit close, input bit fs_pix, input bit fs_cnt,
                            input int n, input int base, input bit body_cnt);
    logic [PIX_W-1:0] d;
    if (close) begin exp_sig = exp_acc; exp_acc = '0; end
    d = PIX_W'(base * 32'h0001_0203 + 5);
    if (fs_pix && fs_cnt) exp_acc = step(exp_acc, 32'(d));
    cyc(1'b1, fs_pix, d);
    for (int i = 0; i < n; i++) begin
      logic v;
      d = PIX_W'(base * 32'h0000_0931 + i * 32'h0001_1D07 + 1);
      v = (i % 3) != 2;
      if (v && body_cnt) exp_acc = step(exp_acc, 32'(d));
      cyc(1'b0, v, d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, r); check("R1 ctrl", r, 32'h0);
    rd(1'b1, r); check("R1 sig", r, 32'h0);

    // R11 readback of fields, sig address read-only
    wr(1'b0, BIT_EN | BIT_FREE | BIT_SRC | 32'h00A5);
    rd(1'b0, r); check("R11 ctrl fields", r, BIT_EN | BIT_FREE | BIT_SRC | 32'h00A5);
    wr(1'b1, 32'hDEAD_BEEF);
    rd(1'b1, r); check("R11 sig write ignored", r, 32'h0);
    wr(1'b0, BIT_CLR);

    // R2 R3 R4 R5 R9: single-shot sweep over frame counts 0..5
    for (int cnt = 0; cnt <= 5; cnt++) begin
      int nf;
      nf = (cnt == 0) ? 1 : cnt;
      wr(1'b0, BIT_CLR);
      wr(1'b0, BIT_EN | BIT_SRC | 32'(cnt));
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, PIX_W'(32'h55 + k)); // R3 before opening
      exp_acc = '0;
      for (int f = 0; f < nf; f++) send_frame(1'b0, f % 2 == 0, 1'b1, 5 + f + cnt, cnt * 8 + f, 1'b1);
      rd(1'b0, r); check(cnt == 0 ? "R9 not done early" : "R3 not done early", r & BIT_DONE, 32'h0);
      send_frame(1'b1, 1'b1, 1'b0, 4, 99, 1'b0); // R5 closing pixel excluded
      rd(1'b0, r); check(cnt == 0 ? "R9 done" : "R4 done", r & BIT_DONE, BIT_DONE);
      rd(1'b1, r); check(cnt == 0 ? "R9 sig" : "R2 sig", r, exp_sig);
      send_frame(1'b0, 1'b1, 1'b0, 6, 77, 1'b0);
      send_frame(1'b0, 1'b1, 1'b0, 3, 78, 1'b0);
      rd(1'b1, r); check("R5 sig held", r, exp_sig);
      rd(1'b0, r); check("R4 done sticky", r & BIT_DONE, BIT_DONE);
    end

    // R7 clear
    wr(1'b0, BIT_CLR | BIT_EN | BIT_SRC | 32'h3);
    rd(1'b0, r); check("R7 ctrl cleared", r, 32'h0);
    rd(1'b1, r); check("R7 sig cleared", r, 32'h0);

    // R6 free-run, two windows of two frames
    wr(1'b0, BIT_EN | BIT_FREE | BIT_SRC | 32'h2);
    exp_acc = '0;
    send_frame(1'b0, 1'b1, 1'b1, 7, 3, 1'b1);
    send_frame(1'b0, 1'b0, 1'b1, 5, 4, 1'b1);
    send_frame(1'b1, 1'b1, 1'b1, 6, 5, 1'b1);
    rd(1'b1, r); check("R6 window1 sig", r, exp_sig);
    rd(1'b0, r); check("R6 done set", r & BIT_DONE, BIT_DONE);
    send_frame(1'b0, 1'b1, 1'b1, 4, 6, 1'b1);
    send_frame(1'b1, 1'b1, 1'b1, 3, 7, 1'b1);
    rd(1'b1, r); check("R6 window2 sig", r, exp_sig);
    rd(1'b0, r); check("R6 done sticky", r & BIT_DONE, BIT_DONE);

    // R8 disable mid-window
    wr(1'b0, BIT_CLR);
    wr(1'b0, BIT_EN | BIT_SRC | 32'h2);
    send_frame(1'b0, 1'b1, 1'b0, 5, 11, 1'b0);
    wr(1'b0, 32'h0);
    for (int f = 0; f < 4; f++) send_frame(1'b0, 1'b1, 1'b0, 4, 12 + f, 1'b0);
    rd(1'b0, r); check("R8 ctrl zero no done", r, 32'h0);
    rd(1'b1, r); check("R8 sig unchanged", r, 32'h0);

    // R10 source select clear
    wr(1'b0, BIT_EN | 32'h1);
    send_frame(1'b0, 1'b1, 1'b0, 8, 21, 1'b0);
    send_frame(1'b0, 1'b1, 1'b0, 2, 22, 1'b0);
    rd(1'b0, r); check("R10 done", r & BIT_DONE, BIT_DONE);
    rd(1'b1, r); check("R10 sig seed", r, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule